// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small processor core and decides when the core leaves its instruction stream to enter a service routine. It watches a bank of request lines, picks the winner by fixed index order, and tells the core to take the interrupt. It also gives the core the routine's start address, a command to push the return address and a one-cycle acknowledge to the winning source. It holds the single global enable bit. The core sets that bit with an enable instruction or with a return-from-interrupt instruction, and the block clears the bit by itself whenever it takes an interrupt.

Line 0 is the reset request. It outranks every other line, ignores the global enable and the instruction boundary, and sends the core straight to the base vector without saving a return address. Lines 1 and up are maskable. They are taken only on a cycle that ends an instruction while the global enable is set. A maskable request seen at any other time is not lost: it is taken at the first instruction boundary after the enable comes back, provided the source still holds its line.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the global enable is cleared; after reset, with no request active, take_o, push_o and ack_o are all zero.
- R2: When several request lines are active, the one with the lowest index wins, and vec_o equals VEC_BASE plus the winner's index times VEC_STEP (default VEC_STEP 2).
- R3: A request on lines 1 and up causes take_o only in a cycle where boundary_i is 1 and gie_o is 1.
- R4: When a request on lines 1 and up is taken, push_o is 1 in the same cycle.
- R5: gie_o is 0 in the cycle after any cycle in which take_o is 1.
- R6: sei_i or reti_i at a clock edge sets gie_o for the following cycle, unless take_o is 1 in the same cycle, in which case the enable is cleared.
- R7: ack_o has exactly one bit set, at the winner's index, in a cycle where take_o is 1, and it is all zero in every other cycle.
- R8: req_i[0] causes take_o in the same cycle regardless of gie_o and boundary_i, with vec_o equal to VEC_BASE, ack_o equal to 1 and push_o equal to 0.
- R9: A maskable request held while the enable is clear is taken at the first boundary cycle after the enable has been set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NSRC | Request lines; bit 0 is the reset request |
| boundary_i | input | 1 | High on the cycle an instruction completes |
| sei_i | input | 1 | Enable instruction executed; sets the global enable |
| reti_i | input | 1 | Return-from-interrupt executed; sets the global enable |
| take_o | output | 1 | Core must enter the routine at vec_o |
| vec_o | output | AW | Start address of the winner's service routine |
| push_o | output | 1 | Core must push the next instruction's address |
| ack_o | output | NSRC | One-hot acknowledge to the winning source |
| gie_o | output | 1 | Current global enable |

## Verification
take_o, vec_o, push_o and ack_o are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs 1 time unit later, before the next rising edge. The enable bit is registered, so its effect is due one rising edge later. The bench checks gie_o on the falling edge after that rising edge, which also shows whether a later request is taken. The pair sweep sets and clears requests inside the low clock phase, so no rising edge passes while they are set, and the enable is not disturbed between checks.

// File: rtl/irqv_pkg.sv
// Shared defaults for the vectored interrupt controller.
package irqv_pkg;
    localparam int unsigned IRQV_NSRC_DEF = 21;
    localparam int unsigned IRQV_AW_DEF   = 16;
    localparam int unsigned IRQV_STEP_DEF = 2;
endpackage

// File: rtl/irqv_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
// Assumes: the request vector is already sampled/synchronous to the core.
module irqv_prio_pick #(
    parameter int unsigned NSRC = irqv_pkg::IRQV_NSRC_DEF,
    localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic [IDW-1:0]  idx_o,
    output logic            any_o
);
    logic [NSRC:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign seen[g+1]  = seen[g] | req_i[g];
        assign grant_o[g] = req_i[g] & ~seen[g];
    end

    assign any_o = seen[NSRC];

    // Encode the one-hot grant into a binary index.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (grant_o[k]) idx_o = IDW'(k);
        end
    end

    // R2
    grant_onehot_chk: assert final ($onehot0(grant_o));
    // R2
    grant_in_req_chk: assert final ((grant_o & ~req_i) == '0);
endmodule

// File: rtl/irqv_vec_calc.sv
// Vector address generator: base plus index times a fixed step.
// Assumes: the index is in range; the result wraps at AW bits.
module irqv_vec_calc #(
    parameter int unsigned IDW      = 5,
    parameter int unsigned AW       = irqv_pkg::IRQV_AW_DEF,
    parameter int unsigned VEC_BASE = 0,
    parameter int unsigned VEC_STEP = irqv_pkg::IRQV_STEP_DEF
) (
    input  logic [IDW-1:0] idx_i,
    output logic [AW-1:0]  vec_o
);
    localparam logic [AW-1:0] BASE_W = AW'(VEC_BASE);
    localparam logic [AW-1:0] STEP_W = AW'(VEC_STEP);

    // Form the routine start address.
    always_comb vec_o = BASE_W + AW'(idx_i) * STEP_W;
endmodule

// File: rtl/irqv_gie.sv
// Global interrupt enable bit. A clear request beats a set request.
// Assumes: set and clear arrive as single-cycle strobes from the core.
module irqv_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic gie_o
);
    // Update the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     gie_o <= 1'b0;
        else if (clr_i) gie_o <= 1'b0;
        else if (set_i) gie_o <= 1'b1;
    end

    // R5
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !gie_o);
    // R6
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> gie_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt controller top. Line 0 is the unmaskable reset
// request. Lines 1 and up are taken only at an instruction boundary
// while the global enable is set. Taking an interrupt clears the enable.
// Assumes: the core acts on take_o in the same cycle and holds a request
// until it is acknowledged.
module irq_vector_ctrl #(
    parameter int unsigned NSRC     = irqv_pkg::IRQV_NSRC_DEF,
    parameter int unsigned AW       = irqv_pkg::IRQV_AW_DEF,
    parameter int unsigned VEC_BASE = 0,
    parameter int unsigned VEC_STEP = irqv_pkg::IRQV_STEP_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            boundary_i,
    input  logic            sei_i,
    input  logic            reti_i,
    output logic            take_o,
    output logic [AW-1:0]   vec_o,
    output logic            push_o,
    output logic [NSRC-1:0] ack_o,
    output logic            gie_o
);
    localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] grant;
    logic [IDW-1:0]  win_idx;
    logic            any_req;
    logic            gie_q;

    irqv_prio_pick #(.NSRC(NSRC)) u_pick (
        .req_i   (req_i),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_req)
    );

    irqv_vec_calc #(.IDW(IDW), .AW(AW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_vec (
        .idx_i (win_idx),
        .vec_o (vec_o)
    );

    irqv_gie u_gie (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sei_i | reti_i),
        .clr_i (take_o),
        .gie_o (gie_q)
    );

    // Decide entry and drive the core-facing commands.
    always_comb begin
        take_o = grant[0] | (any_req & boundary_i & gie_q);
        push_o = take_o & ~grant[0];
        ack_o  = take_o ? grant : '0;
    end

    assign gie_o = gie_q;

    // R8
    rst_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |-> (take_o && !push_o && ack_o[0]));
    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !req_i[0]) |-> (boundary_i && gie_o));
    // R4
    push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !ack_o[0]) |-> push_o);
    // R7
    ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(ack_o) == 1));
    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (ack_o == '0));
    // R5
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    localparam int CLK_P = 10;
    localparam int N     = 21;
    localparam int AW    = 16;
    localparam int BASE  = 'h40;
    localparam int STEP  = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic bnd = 1'b0, sei = 1'b0, reti = 1'b0;
    logic take, push, gie;
    logic [AW-1:0] vec;
    logic [N-1:0] ack;
    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_vector_ctrl #(.NSRC(N), .AW(AW), .VEC_BASE(BASE), .VEC_STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .boundary_i(bnd),
        .sei_i(sei), .reti_i(reti), .take_o(take), .vec_o(vec),
        .push_o(push), .ack_o(ack), .gie_o(gie)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // one rising edge, then back to the falling edge
    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle();
        req = '0; bnd = 0; sei = 0; reti = 0;
    endtask

    task automatic enable();
        idle(); sei = 1; tick(); sei = 0; #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1; #1;
        chk("R1 gie", gie, 0);
        chk("R1 take", take, 0);
        chk("R1 push", push, 0);
        chk("R1 ack", ack, 0);

        // R3: enable clear blocks a maskable request at a boundary
        req = 1 << 7; bnd = 1; #1;
        chk("R3 gie0", take, 0);
        idle(); enable();
        chk("R6 sei", gie, 1);
        // R3: boundary low blocks it even with the enable set
        req = 1 << 7; bnd = 0; #1;
        chk("R3 bnd0", take, 0);
        chk("R7 idle", ack, 0);
        idle(); #1;

        // single-source sweep
        for (int i = 1; i < N; i++) begin
            enable();
            req = 1 << i; bnd = 1; #1;
            chk("R3 take", take, 1);
            chk("R2 vec", vec, BASE + i * STEP);
            chk("R4 push", push, 1);
            chk("R7 ack", ack, 1 << i);
            tick(); idle(); #1;
            chk("R5 gie", gie, 0);
        end

        // all pairs: lower index wins (no edge passes while set)
        enable();
        for (int i = 1; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                @(negedge clk);
                req = (1 << i) | (1 << j); bnd = 1; #1;
                chk("R2 pair vec", vec, BASE + i * STEP);
                chk("R7 pair ack", ack, 1 << i);
                req = '0; bnd = 0; #1;
            end
        end
        chk("R6 gie kept", gie, 1);

        // R6: take in the same cycle as sei clears the enable
        req = 1 << 3; bnd = 1; sei = 1; #1;
        chk("R6 take", take, 1);
        tick(); idle(); #1;
        chk("R6 clr wins", gie, 0);

        // R9: request held while disabled, taken after reti at boundary
        req = 1 << 5; bnd = 1;
        tick(); #1;
        chk("R9 wait", take, 0);
        reti = 1; tick(); reti = 0; bnd = 0; #1;
        chk("R6 reti", gie, 1);
        chk("R9 no bnd", take, 0);
        bnd = 1; #1;
        chk("R9 take", take, 1);
        chk("R9 vec", vec, BASE + 5 * STEP);
        tick(); idle(); #1;

        // R8: reset request ignores enable and boundary
        req = (1 << 0) | (1 << 4); #1;
        chk("R8 take", take, 1);
        chk("R8 vec", vec, BASE);
        chk("R8 push", push, 0);
        chk("R8 ack", ack, 1);
        idle(); enable();
        req = 1; #1;
        chk("R8 gie1 take", take, 1);
        tick(); idle(); #1;
        chk("R8 clr", gie, 0);

        // R1: reset clears a set enable
        enable();
        rst_n = 0; tick(); rst_n = 1; #1;
        chk("R1 rst", gie, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule